// File: doc/BRIEF.md
# Dual-Half Prescaled Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves. A clock divider runs ahead of the halves. It has a fixed stage that divides the cycle clock by four, followed by an 8-bit reloadable down-counter. Together they produce the timer tick. A single external event line is brought into the clock domain through a two-flop synchronizer. Each rising edge on that line becomes a one-cycle event strobe.

A two-bit mode field sets how the halves are used:
- **Mode 0:** two separate timers.
- **Mode 1:** a timer in the low half and an event counter in the high half.
- **Mode 2:** one 16-bit timer.
- **Mode 3:** one 16-bit event counter.

Every half, or the joined pair, counts up to its compare value. On the next count it returns to zero and sets a sticky request flag. Software clears the flag through the register bus. Each half drives its own request line.

Software reaches the block through a small bus. Writes take effect on the clock edge. Reads are combinational from the read address.

Top module: `dual_half_timer`

## Requirements
- R1: After reset both counts read 0, both request outputs are low, the mode reads 0, the reload reads 0 and both compare values read 8'hFF.
- R2: The timer tick occurs every FIX_DIV*(reload+1) clock cycles (FIX_DIV = 4). Counting starts at the edge that wrote the mode or the reload register. The first tick lands FIX_DIV*(reload+1) edges after that write.
- R3: In mode 0 each half counts timer ticks on its own. A half whose count equals its compare value goes to 0 on the next tick and sets its own request flag in the same edge.
- R4: In mode 1 the low half behaves as in R3. The high half counts rising edges of `evtIn` with the same compare rule. A high level of any length counts once, and each edge is counted by the third clock edge after it. In modes 0 and 2 `evtIn` has no effect.
- R5: In mode 2 the halves form one 16-bit timer {high,low} compared against {matchHigh,matchLow}. On a tick at equality the pair clears and the high request is set.
- R6: In mode 3 the halves form one 16-bit counter of `evtIn` rising edges, with the same compare and request rule as R5.
- R7: In modes 2 and 3 the low request flag is never set.
- R8: A request flag stays set until a write to address 4 with a 1 in its bit (bit 0 low, bit 1 high). A set in the same edge as a clear wins.
- R9: Writing the mode register clears both counts and both request flags and restarts both prescaler stages.
- R10: Writing the reload register restarts both prescaler stages with the new value without touching the counts.
- R11: Register map, read and write: 0 mode in bits [1:0], 1 reload, 2 matchLow, 3 matchHigh, 4 flags (read bit 0 low, bit 1 high; write 1 to clear). Read only: 5 low count, 6 high count. Other addresses read 0.
- R12: Writing a compare value leaves both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | HALF_W | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | HALF_W | Read data, combinational |
| evtIn | input | 1 | External event line, asynchronous |
| irqLow | output | 1 | Low half request flag |
| irqHigh | output | 1 | High half / 16-bit request flag |

## Verification
The bench sets every parameter explicitly to its default: 8-bit halves, an 8-bit reload and a divide-by-four fixed stage. Small random reloads keep each tick within a few dozen cycles, so many compare wraps in every mode fit inside a short run. Those short periods also make a 256-event carry from the low half into the high half and a 16-bit wrap at a compare value of 16'h0100 reachable with a thousand or so cycles of pulses.

// File: rtl/dht_pkg.sv
`timescale 1ns/100ps
package dht_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT      = 2'd0,
    MODE_TIMER_EVT  = 2'd1,
    MODE_CASC_TIMER = 2'd2,
    MODE_CASC_EVT   = 2'd3
  } mode_e;

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_RELOAD = 3'd1;
  localparam logic [2:0] ADDR_MLOW   = 3'd2;
  localparam logic [2:0] ADDR_MHIGH  = 3'd3;
  localparam logic [2:0] ADDR_FLAGS  = 3'd4;
  localparam logic [2:0] ADDR_CLOW   = 3'd5;
  localparam logic [2:0] ADDR_CHIGH  = 3'd6;

  typedef struct packed {
    logic lowTick;
    logic highTick;
    logic cascade;
    logic clrAll;
    logic clrLowFlag;
    logic clrHighFlag;
    logic wrMatchLow;
    logic wrMatchHigh;
  } strobe_t;

endpackage

// File: rtl/dht_ctrl.sv
`timescale 1ns/100ps
module dht_ctrl
  import dht_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 8,
  parameter int FIX_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtIn,
  output strobe_t           strb,
  output mode_e             modeQ,
  output logic [PRE_W-1:0]  reloadQ
);

  localparam int FIX_W = (FIX_DIV > 2) ? $clog2(FIX_DIV) : 1;
  localparam logic [FIX_W-1:0] FIX_LAST = FIX_W'(FIX_DIV - 1);

  logic [FIX_W-1:0]       fixCnt;
  logic [PRE_W-1:0]       preCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   evtPrev;
  logic                   wrMode, wrReload, restartPre;
  logic                   fixTick, preTick, evtRise;

  assign wrMode     = wrEn && (wrAddr == ADDR_MODE);
  assign wrReload   = wrEn && (wrAddr == ADDR_RELOAD);
  assign restartPre = wrMode || wrReload;

  // fixed divider followed by the reloadable down-counter
  assign fixTick = (fixCnt == FIX_LAST);
  assign preTick = fixTick && (preCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_SPLIT;
      reloadQ <= '0;
      fixCnt  <= '0;
      preCnt  <= '0;
    end else begin
      if (wrMode)   modeQ   <= mode_e'(wrData[1:0]);
      if (wrReload) reloadQ <= wrData[PRE_W-1:0];
      if (restartPre) begin
        fixCnt <= '0;
        preCnt <= wrReload ? wrData[PRE_W-1:0] : reloadQ;
      end else begin
        fixCnt <= fixTick ? '0 : fixCnt + 1'b1;
        if (fixTick) preCnt <= (preCnt == '0) ? reloadQ : preCnt - 1'b1;
      end
    end
  end

  // event line: synchronizer chain, then rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      evtPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], evtIn};
      evtPrev <= syncQ[SYNC_STAGES-1];
    end
  end
  assign evtRise = syncQ[SYNC_STAGES-1] && !evtPrev;

  always_comb begin
    strb             = '0;
    strb.clrAll      = wrMode;
    strb.clrLowFlag  = wrEn && (wrAddr == ADDR_FLAGS) && wrData[0];
    strb.clrHighFlag = wrEn && (wrAddr == ADDR_FLAGS) && wrData[1];
    strb.wrMatchLow  = wrEn && (wrAddr == ADDR_MLOW);
    strb.wrMatchHigh = wrEn && (wrAddr == ADDR_MHIGH);
    unique case (modeQ)
      MODE_SPLIT: begin
        strb.lowTick  = preTick;
        strb.highTick = preTick;
      end
      MODE_TIMER_EVT: begin
        strb.lowTick  = preTick;
        strb.highTick = evtRise;
      end
      MODE_CASC_TIMER: begin
        strb.cascade = 1'b1;
        strb.lowTick = preTick;
      end
      MODE_CASC_EVT: begin
        strb.cascade = 1'b1;
        strb.lowTick = evtRise;
      end
      default: ;
    endcase
  end

  // R4: one strobe per edge of the event line
  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rstN)
    evtRise |=> !evtRise);

  // R2: prescaler tick never lasts two cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    preTick |=> !preTick);

  // R10: a reload write leaves the divider at its start point
  a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
    wrReload |=> (fixCnt == '0) && (preCnt == $past(wrData[PRE_W-1:0])));

endmodule

// File: rtl/dht_datapath.sv
`timescale 1ns/100ps
module dht_datapath
  import dht_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] cntLow,
  output logic [HALF_W-1:0] cntHigh,
  output logic [HALF_W-1:0] matchLow,
  output logic [HALF_W-1:0] matchHigh,
  output logic              flagLow,
  output logic              flagHigh
);

  localparam int WIDE_W = 2 * HALF_W;

  logic              lowHit, highHit, wideHit;
  logic              setLow, setHigh;
  logic [WIDE_W-1:0] wideNext;

  assign lowHit   = (cntLow == matchLow);
  assign highHit  = (cntHigh == matchHigh);
  assign wideHit  = lowHit && highHit;
  assign wideNext = {cntHigh, cntLow} + 1'b1;

  assign setLow  = !strb.cascade && strb.lowTick && lowHit;
  assign setHigh = strb.cascade ? (strb.lowTick && wideHit)
                                : (strb.highTick && highHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchLow  <= '1;
      matchHigh <= '1;
    end else begin
      if (strb.wrMatchLow)  matchLow  <= wrData;
      if (strb.wrMatchHigh) matchHigh <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLow  <= '0;
      cntHigh <= '0;
    end else if (strb.clrAll) begin
      cntLow  <= '0;
      cntHigh <= '0;
    end else if (strb.cascade) begin
      if (strb.lowTick) {cntHigh, cntLow} <= wideHit ? '0 : wideNext;
    end else begin
      if (strb.lowTick)  cntLow  <= lowHit  ? '0 : cntLow + 1'b1;
      if (strb.highTick) cntHigh <= highHit ? '0 : cntHigh + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagLow  <= 1'b0;
      flagHigh <= 1'b0;
    end else if (strb.clrAll) begin
      flagLow  <= 1'b0;
      flagHigh <= 1'b0;
    end else begin
      if (setLow)               flagLow  <= 1'b1;
      else if (strb.clrLowFlag) flagLow  <= 1'b0;
      if (setHigh)               flagHigh <= 1'b1;
      else if (strb.clrHighFlag) flagHigh <= 1'b0;
    end
  end

  // R8: flags hold until cleared
  a_r8_low_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flagLow && !strb.clrLowFlag && !strb.clrAll |=> flagLow);
  a_r8_high_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flagHigh && !strb.clrHighFlag && !strb.clrAll |=> flagHigh);

  // R7: joined modes never raise the low request
  a_r7_no_low_req: assert property (@(posedge clk) disable iff (!rstN)
    strb.cascade && !flagLow |=> !flagLow);

  // R9: a mode write empties counts and flags
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (cntLow == '0) && (cntHigh == '0) && !flagLow && !flagHigh);

  // R12: without a tick the low count holds, compare writes included
  a_r12_low_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lowTick && !strb.clrAll |=> $stable(cntLow));

endmodule

// File: rtl/dual_half_timer.sv
`timescale 1ns/100ps
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 8,
  parameter int FIX_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [HALF_W-1:0] rdData,
  input  logic              evtIn,
  output logic              irqLow,
  output logic              irqHigh
);

  strobe_t           strb;
  mode_e             modeQ;
  logic [PRE_W-1:0]  reloadQ;
  logic [HALF_W-1:0] cntLow, cntHigh, matchLow, matchHigh;
  logic              flagLow, flagHigh;

  dht_ctrl #(
    .DATA_W(HALF_W), .PRE_W(PRE_W), .FIX_DIV(FIX_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtIn(evtIn), .strb(strb), .modeQ(modeQ), .reloadQ(reloadQ)
  );

  dht_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cntLow(cntLow), .cntHigh(cntHigh), .matchLow(matchLow),
    .matchHigh(matchHigh), .flagLow(flagLow), .flagHigh(flagHigh)
  );

  assign irqLow  = flagLow;
  assign irqHigh = flagHigh;

  always_comb begin
    unique case (rdAddr)
      ADDR_MODE:   rdData = HALF_W'(modeQ);
      ADDR_RELOAD: rdData = HALF_W'(reloadQ);
      ADDR_MLOW:   rdData = matchLow;
      ADDR_MHIGH:  rdData = matchHigh;
      ADDR_FLAGS:  rdData = HALF_W'({flagHigh, flagLow});
      ADDR_CLOW:   rdData = cntLow;
      ADDR_CHIGH:  rdData = cntHigh;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: tb/dual_half_timer_test.sv
`timescale 1ns/100ps
module dual_half_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       evtIn = 1'b0;
  logic       irqLow, irqHigh;

  int nChecks = 0;
  int nFails  = 0;
  int cycCnt  = 0;

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) cycCnt <= cycCnt + 1;

  dual_half_timer #(.HALF_W(8), .PRE_W(8), .FIX_DIV(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rdAddr = a;
    #0.1;
    v = int'(rdData);
  endtask

  task automatic pulse();
    @(negedge clk); evtIn = 1'b1;
    repeat (2) @(negedge clk);
    evtIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int ticksOf(input int w, input int reload);
    return w / (4 * (reload + 1));
  endfunction

  function automatic int wrapCount(input int n, input int m);
    return n % (m + 1);
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int v, v2, t0, w, tk;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 map
    check(int'(irqLow), 0, "R1 irqLow");
    check(int'(irqHigh), 0, "R1 irqHigh");
    rd(3'd0, v); check(v, 0, "R1 mode");
    rd(3'd1, v); check(v, 0, "R1 reload");
    rd(3'd2, v); check(v, 255, "R1 matchLow");
    rd(3'd3, v); check(v, 255, "R1 matchHigh");
    rd(3'd5, v); check(v, 0, "R1 cntLow");
    rd(3'd6, v); check(v, 0, "R1 cntHigh");
    rd(3'd7, v); check(v, 0, "R11 unused addr");

    // R10: reload write restarts the divider, counts untouched
    wr(3'd1, 8'd255);
    wr(3'd0, 8'd0);
    repeat (10) @(negedge clk);
    wr(3'd1, 8'd0);
    t0 = cycCnt;
    rd(3'd1, v); check(v, 0, "R11 reload readback");
    repeat (41) @(negedge clk);
    w = cycCnt - t0;
    rd(3'd5, v); check(v, ticksOf(w, 0), "R10 cntLow after restart");
    rd(3'd6, v); check(v, ticksOf(w, 0), "R10 cntHigh after restart");

    // R8 sticky flags and write-one-to-clear
    wr(3'd2, 8'd5);
    wr(3'd3, 8'd5);
    wr(3'd0, 8'd0);
    repeat (26) @(negedge clk);
    check(int'(irqLow), 1, "R8 low set");
    check(int'(irqHigh), 1, "R8 high set");
    wr(3'd4, 8'd1);
    check(int'(irqLow), 0, "R8 low cleared");
    check(int'(irqHigh), 1, "R8 high stays");
    rd(3'd4, v); check(v, 2, "R11 flag readback");
    // R9 mode write clears everything
    wr(3'd0, 8'd1);
    check(int'(irqHigh), 0, "R9 flag cleared");
    rd(3'd5, v); check(v, 0, "R9 cntLow cleared");
    rd(3'd0, v); check(v, 1, "R11 mode readback");

    // R4 a long high level counts once
    wr(3'd3, 8'd255);
    wr(3'd0, 8'd1);
    @(negedge clk); evtIn = 1'b1;
    repeat (50) @(negedge clk);
    evtIn = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd6, v); check(v, 1, "R4 long level counts once");

    // R6 carry across the halves, R12 compare write, R7 no low request
    wr(3'd2, 8'd0);
    wr(3'd3, 8'd1);
    wr(3'd0, 8'd3);
    for (int i = 0; i < 256; i++) pulse();
    repeat (4) @(negedge clk);
    rd(3'd5, v); rd(3'd6, v2);
    check(v, 0, "R6 carry low");
    check(v2, 1, "R6 carry high");
    check(int'(irqHigh), 0, "R6 no request before wrap");
    pulse(); repeat (4) @(negedge clk);
    rd(3'd6, v2); check(v2, 0, "R6 wrap high");
    check(int'(irqHigh), 1, "R6 request at wrap");
    check(int'(irqLow), 0, "R7 no low request");
    for (int i = 0; i < 5; i++) pulse();
    repeat (4) @(negedge clk);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd0);
    rd(3'd5, v); check(v, 5, "R12 count kept after compare write");

    // random mixed runs
    for (int it = 0; it < 40; it++) begin
      int md, rl, ml, mh, np, ex, expL, expH, fL, fH;
      md = $urandom % 4;
      rl = $urandom % 4;
      np = $urandom % 30;
      ex = 4 + ($urandom % 150);
      if (md >= 2) begin mh = $urandom % 2; ml = $urandom % 40; end
      else begin mh = $urandom % 12; ml = $urandom % 12; end
      wr(3'd1, 8'(rl));
      wr(3'd2, 8'(ml));
      wr(3'd3, 8'(mh));
      wr(3'd0, 8'(md));
      t0 = cycCnt;
      for (int p = 0; p < np; p++) pulse();
      repeat (ex) @(negedge clk);
      w  = cycCnt - t0;
      tk = ticksOf(w, rl);
      fL = 0; fH = 0;
      case (md)
        0: begin
          expL = wrapCount(tk, ml); expH = wrapCount(tk, mh);
          fL = int'(tk > ml); fH = int'(tk > mh);
        end
        1: begin
          expL = wrapCount(tk, ml); expH = wrapCount(np, mh);
          fL = int'(tk > ml); fH = int'(np > mh);
        end
        default: begin
          int n, m16, c;
          n   = (md == 2) ? tk : np;
          m16 = mh * 256 + ml;
          c   = wrapCount(n, m16);
          expL = c % 256; expH = c / 256;
          fH = int'(n > m16);
        end
      endcase
      rd(3'd5, v); rd(3'd6, v2);
      case (md)
        0: begin
          check(v, expL, "R3 low count"); check(v2, expH, "R3 high count");
          check(int'(irqLow), fL, "R3 low req"); check(int'(irqHigh), fH, "R3 high req");
        end
        1: begin
          check(v, expL, "R2 low timer count"); check(v2, expH, "R4 event count");
          check(int'(irqLow), fL, "R2 low req"); check(int'(irqHigh), fH, "R4 high req");
        end
        2: begin
          check(v, expL, "R5 low byte"); check(v2, expH, "R5 high byte");
          check(int'(irqLow), 0, "R7 low req"); check(int'(irqHigh), fH, "R5 req");
        end
        default: begin
          check(v, expL, "R6 low byte"); check(v2, expH, "R6 high byte");
          check(int'(irqLow), 0, "R7 low req"); check(int'(irqHigh), fH, "R6 req");
        end
      endcase
    end

    finishRun();
  end

endmodule